// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power depth a processor subsystem sits in and drives the enables that go with that depth. While the subsystem runs, the core may pulse a wait-for-interrupt or a wait-for-event strobe. Two control bits then pick the depth. With the deep-sleep bit clear, only the core clock is stopped (Sleep). With deep-sleep set and power-down clear, every core-domain clock and both high-speed oscillators stop, and the regulator stays on (Stop). With both bits set, the regulator is switched off as well (Standby).

Each depth has its own set of wakeup sources, which are plain level inputs. Sleep entered by wait-for-interrupt wakes on an enabled interrupt. Sleep entered by wait-for-event wakes on an event. Stop wakes on any external-line input. Standby wakes only on a rising edge of the wakeup pin, an RTC source, the external reset pin or the watchdog reset. Because Standby loses state, leaving it produces a one-cycle reset request. The core, the oscillators and the regulator appear only as enable outputs. All pins are plain control levels, so the block has no valid/ready interface and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: During and right after reset the block is in Run: cpu_clk_en_o, dom_clk_en_o, osc_en_o and reg_on_o are 1, and reg_lp_o and stby_rst_o are 0.
- R2: In Run, a wfi_i or wfe_i pulse with deep_i=0 puts the block in Sleep from the next cycle: cpu_clk_en_o=0, dom_clk_en_o=1, osc_en_o=1, reg_on_o=1, reg_lp_o=0. Without a strobe the block stays in Run.
- R3: Sleep entered through wfi_i (wfi_i wins when both strobes are high) returns to Run in the cycle after any bit of irq_i & irq_en_i is 1. Masked interrupts, evt_i and all other wakeup inputs leave it asleep.
- R4: Sleep entered through wfe_i alone returns to Run in the cycle after evt_i is 1. Interrupts, even enabled ones, and all other wakeup inputs leave it asleep.
- R5: A strobe with deep_i=1 and pdown_i=0 enters Stop on the next cycle: all clock and oscillator enables are 0 and reg_on_o=1. reg_lp_o equals lpreg_i as sampled in the strobe cycle and holds for the whole stay, even if lpreg_i changes later.
- R6: Stop reacts only to a 1 on any bit of xline_i. On the next cycle osc_en_o=1, reg_on_o=1 and reg_lp_o=0 while both clock enables are still 0. The cycle after that is Run. Interrupts, events, RTC inputs and both reset inputs are ignored in Stop.
- R7: A strobe with deep_i=1 and pdown_i=1 enters Standby on the next cycle, with all six outputs 0.
- R8: Standby reacts to a 0-to-1 change of wkpin_i, to any bit of rtc_i, to ext_rst_i or to wdog_rst_i. The next cycle has stby_rst_o=1, osc_en_o=1, reg_on_o=1 and both clock enables 0. The cycle after that is Run. External lines, interrupts and events are ignored in Standby.
- R9: A wkpin_i that is already 1 when Standby is entered does not wake it. Only a later fall followed by a rise does.
- R10: stby_rst_o is 1 only in the single cycle after Standby is left. Exits from Sleep or Stop never raise it.
- R11: Wait strobes and the deep_i, pdown_i and lpreg_i bits have no effect while the block is in any mode other than Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the core |
| wfe_i | input | 1 | Wait-for-event strobe from the core |
| deep_i | input | 1 | Deep-sleep select |
| pdown_i | input | 1 | Power-down select (Standby instead of Stop) |
| lpreg_i | input | 1 | Low-power regulator select for Stop |
| irq_i | input | IRQ_W | Interrupt lines |
| irq_en_i | input | IRQ_W | Interrupt enables |
| evt_i | input | 1 | Wakeup event |
| xline_i | input | EXT_W | External and internal wakeup lines |
| wkpin_i | input | 1 | Wakeup pin level |
| rtc_i | input | RTC_W | RTC alarm, wakeup, tamper and timestamp sources |
| ext_rst_i | input | 1 | External reset pin request |
| wdog_rst_i | input | 1 | Watchdog reset request |
| cpu_clk_en_o | output | 1 | Core clock enable |
| dom_clk_en_o | output | 1 | Core-domain clock enable |
| osc_en_o | output | 1 | High-speed oscillator enable |
| reg_on_o | output | 1 | Regulator on |
| reg_lp_o | output | 1 | Regulator in low-power mode |
| stby_rst_o | output | 1 | One-cycle reset request after Standby |

## Verification
The bench walks all 32 combinations of the two strobes and the three select bits from Run. In each resulting depth it first drives every wakeup source that the depth must ignore, together with fresh strobes, and only then the source that should wake it. A design that mixed up the source sets would wake early or get stuck, and one that honoured strobes outside Run would drop a Sleep into Stop. Stop exits are checked cycle by cycle for the oscillator-first restore, and Standby exits for a one-cycle reset request that Sleep and Stop exits never show. A separate case holds the wakeup pin high into Standby: a level-sensitive design would wake at once, and one with a stale pin register would miss the later rise.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLP_IRQ,
    ST_SLP_EVT,
    ST_STOP,
    ST_STOP_RCV,
    ST_STBY,
    ST_STBY_RCV
  } lpm_state_e;

  typedef struct packed {
    logic cpu_clk;
    logic dom_clk;
    logic osc;
    logic reg_on;
    logic reg_lp;
    logic stby_rst;
  } lpm_ctl_t;

  typedef struct packed {
    logic irq;
    logic evt;
    logic xline;
    logic stby;
  } lpm_wake_t;

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
  import lpm_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int EXT_W = 4,
  parameter int RTC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             evt_i,
  input  logic [EXT_W-1:0] xline_i,
  input  logic             wkpin_i,
  input  logic [RTC_W-1:0] rtc_i,
  input  logic             ext_rst_i,
  input  logic             wdog_rst_i,
  output lpm_wake_t        wake_o
);

  logic             pin_q;
  logic             pin_rise;
  logic [IRQ_W-1:0] irq_live;

  // registered copy of the pin; a rise needs a low sample first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= wkpin_i;
  end

  assign pin_rise = wkpin_i & ~pin_q;

  genvar gi;
  generate
    for (gi = 0; gi < IRQ_W; gi++) begin : g_irq
      assign irq_live[gi] = irq_i[gi] & irq_en_i[gi];
    end
  endgenerate

  always_comb begin
    wake_o.irq   = |irq_live;
    wake_o.evt   = evt_i;
    wake_o.xline = |xline_i;
    wake_o.stby  = pin_rise | (|rtc_i) | ext_rst_i | wdog_rst_i;
  end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       deep_i,
  input  logic       pdown_i,
  input  logic       lpreg_i,
  input  lpm_wake_t  wake_i,
  output lpm_state_e state_o,
  output logic       lp_q_o
);

  lpm_state_e state_q, state_d;
  logic       lp_q, lp_d;
  logic       strobe;

  assign strobe = wfi_i | wfe_i;

  always_comb begin
    state_d = state_q;
    lp_d    = lp_q;
    unique case (state_q)
      ST_RUN: begin
        if (strobe) begin
          if (!deep_i) begin
            state_d = wfi_i ? ST_SLP_IRQ : ST_SLP_EVT;
          end else if (!pdown_i) begin
            state_d = ST_STOP;
            lp_d    = lpreg_i;
          end else begin
            state_d = ST_STBY;
          end
        end
      end
      ST_SLP_IRQ:  if (wake_i.irq)   state_d = ST_RUN;
      ST_SLP_EVT:  if (wake_i.evt)   state_d = ST_RUN;
      ST_STOP: begin
        if (wake_i.xline) begin
          state_d = ST_STOP_RCV;
          lp_d    = 1'b0;
        end
      end
      ST_STOP_RCV: state_d = ST_RUN;
      ST_STBY:     if (wake_i.stby)  state_d = ST_STBY_RCV;
      ST_STBY_RCV: state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      lp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      lp_q    <= lp_d;
    end
  end

  assign state_o = state_q;
  assign lp_q_o  = lp_q;

endmodule

// File: rtl/lpm_out.sv
module lpm_out
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       lp_q_i,
  output lpm_ctl_t   ctl_o
);

  always_comb begin
    ctl_o = '0;
    unique case (state_i)
      ST_RUN:      ctl_o = '{cpu_clk: 1'b1, dom_clk: 1'b1, osc: 1'b1, reg_on: 1'b1, reg_lp: 1'b0, stby_rst: 1'b0};
      ST_SLP_IRQ,
      ST_SLP_EVT:  ctl_o = '{cpu_clk: 1'b0, dom_clk: 1'b1, osc: 1'b1, reg_on: 1'b1, reg_lp: 1'b0, stby_rst: 1'b0};
      ST_STOP:     ctl_o = '{cpu_clk: 1'b0, dom_clk: 1'b0, osc: 1'b0, reg_on: 1'b1, reg_lp: lp_q_i, stby_rst: 1'b0};
      ST_STOP_RCV: ctl_o = '{cpu_clk: 1'b0, dom_clk: 1'b0, osc: 1'b1, reg_on: 1'b1, reg_lp: 1'b0, stby_rst: 1'b0};
      ST_STBY:     ctl_o = '0;
      ST_STBY_RCV: ctl_o = '{cpu_clk: 1'b0, dom_clk: 1'b0, osc: 1'b1, reg_on: 1'b1, reg_lp: 1'b0, stby_rst: 1'b1};
      default:     ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int EXT_W = 4,
  parameter int RTC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             deep_i,
  input  logic             pdown_i,
  input  logic             lpreg_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             evt_i,
  input  logic [EXT_W-1:0] xline_i,
  input  logic             wkpin_i,
  input  logic [RTC_W-1:0] rtc_i,
  input  logic             ext_rst_i,
  input  logic             wdog_rst_i,
  output logic             cpu_clk_en_o,
  output logic             dom_clk_en_o,
  output logic             osc_en_o,
  output logic             reg_on_o,
  output logic             reg_lp_o,
  output logic             stby_rst_o
);

  lpm_wake_t  wake;
  lpm_state_e state;
  logic       lp_q;
  lpm_ctl_t   ctl;

  lpm_wake #(.IRQ_W(IRQ_W), .EXT_W(EXT_W), .RTC_W(RTC_W)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .irq_en_i   (irq_en_i),
    .evt_i      (evt_i),
    .xline_i    (xline_i),
    .wkpin_i    (wkpin_i),
    .rtc_i      (rtc_i),
    .ext_rst_i  (ext_rst_i),
    .wdog_rst_i (wdog_rst_i),
    .wake_o     (wake)
  );

  lpm_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wfi_i   (wfi_i),
    .wfe_i   (wfe_i),
    .deep_i  (deep_i),
    .pdown_i (pdown_i),
    .lpreg_i (lpreg_i),
    .wake_i  (wake),
    .state_o (state),
    .lp_q_o  (lp_q)
  );

  lpm_out u_out (
    .state_i (state),
    .lp_q_i  (lp_q),
    .ctl_o   (ctl)
  );

  assign cpu_clk_en_o = ctl.cpu_clk;
  assign dom_clk_en_o = ctl.dom_clk;
  assign osc_en_o     = ctl.osc;
  assign reg_on_o     = ctl.reg_on;
  assign reg_lp_o     = ctl.reg_lp;
  assign stby_rst_o   = ctl.stby_rst;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int IRQ_W = 4,
  parameter int EXT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wfi_i,
  input logic             wfe_i,
  input logic             deep_i,
  input logic             pdown_i,
  input logic             lpreg_i,
  input logic [IRQ_W-1:0] irq_i,
  input logic [IRQ_W-1:0] irq_en_i,
  input logic             evt_i,
  input logic [EXT_W-1:0] xline_i,
  input logic             cpu_clk_en_o,
  input logic             dom_clk_en_o,
  input logic             osc_en_o,
  input logic             reg_on_o,
  input logic             reg_lp_o,
  input logic             stby_rst_o
);

  logic in_run, in_sleep, in_stop, strobe;
  assign in_run   = cpu_clk_en_o;
  assign in_sleep = !cpu_clk_en_o && dom_clk_en_o;
  assign in_stop  = !dom_clk_en_o && !osc_en_o && reg_on_o;
  assign strobe   = wfi_i || wfe_i;

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && strobe && !deep_i |=> !cpu_clk_en_o && dom_clk_en_o && osc_en_o && reg_on_o);

  p_stop_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && strobe && deep_i && !pdown_i |=>
      !dom_clk_en_o && !osc_en_o && reg_on_o && (reg_lp_o == $past(lpreg_i)));

  p_stop_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop && (|xline_i) |=> osc_en_o && reg_on_o && !reg_lp_o && !dom_clk_en_o && !stby_rst_o);

  p_stby_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && strobe && deep_i && pdown_i |=> !reg_on_o && !osc_en_o && !dom_clk_en_o);

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stby_rst_o |=> !stby_rst_o && cpu_clk_en_o);

  p_rst_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_rst_o) |-> $past(!reg_on_o));

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep && !evt_i && ((irq_i & irq_en_i) == '0) |=> !cpu_clk_en_o && dom_clk_en_o);

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.IRQ_W(IRQ_W), .EXT_W(EXT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wfi_i        (wfi_i),
  .wfe_i        (wfe_i),
  .deep_i       (deep_i),
  .pdown_i      (pdown_i),
  .lpreg_i      (lpreg_i),
  .irq_i        (irq_i),
  .irq_en_i     (irq_en_i),
  .evt_i        (evt_i),
  .xline_i      (xline_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .dom_clk_en_o (dom_clk_en_o),
  .osc_en_o     (osc_en_o),
  .reg_on_o     (reg_on_o),
  .reg_lp_o     (reg_lp_o),
  .stby_rst_o   (stby_rst_o)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;

  localparam int IRQ_W = 4;
  localparam int EXT_W = 4;
  localparam int RTC_W = 5;

  localparam int M_RUN = 0, M_SLI = 1, M_SLE = 2, M_STOP = 3, M_STBY = 4;
  localparam logic [5:0] V_RUN   = 6'b111100;
  localparam logic [5:0] V_SLEEP = 6'b011100;
  localparam logic [5:0] V_RCV   = 6'b001100;
  localparam logic [5:0] V_SRST  = 6'b001101;
  localparam logic [5:0] V_STBY  = 6'b000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_i = 0, wfe_i = 0, deep_i = 0, pdown_i = 0, lpreg_i = 0;
  logic [IRQ_W-1:0] irq_i = '0, irq_en_i = '0;
  logic evt_i = 0;
  logic [EXT_W-1:0] xline_i = '0;
  logic wkpin_i = 0;
  logic [RTC_W-1:0] rtc_i = '0;
  logic ext_rst_i = 0, wdog_rst_i = 0;
  logic cpu_clk_en_o, dom_clk_en_o, osc_en_o, reg_on_o, reg_lp_o, stby_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.IRQ_W(IRQ_W), .EXT_W(EXT_W), .RTC_W(RTC_W)) i_lpm_ctrl (.*);

  function automatic logic [5:0] stop_v(input logic lp);
    return {5'b00010, 1'b0} | {4'b0, lp, 1'b0};
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic quiet;
    wfi_i = 0; wfe_i = 0; deep_i = 0; pdown_i = 0; lpreg_i = 0;
    irq_i = '0; irq_en_i = '0; evt_i = 0; xline_i = '0;
    rtc_i = '0; ext_rst_i = 0; wdog_rst_i = 0;
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {cpu_clk_en_o, dom_clk_en_o, osc_en_o, reg_on_o, reg_lp_o, stby_rst_o};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R1 in reset", V_RUN);
    tick; tick;
    rst_n = 1'b1;
    tick;
    chk("R1 after reset", V_RUN);

    for (int c = 0; c < 32; c++) begin
      automatic logic wi = c[0];
      automatic logic we = c[1];
      automatic logic dp = c[2];
      automatic logic pd = c[3];
      automatic logic lp = c[4];
      automatic int   m;
      if (!(wi | we))  m = M_RUN;
      else if (!dp)    m = wi ? M_SLI : M_SLE;
      else if (!pd)    m = M_STOP;
      else             m = M_STBY;

      wfi_i = wi; wfe_i = we; deep_i = dp; pdown_i = pd; lpreg_i = lp;
      tick;
      quiet;
      case (m)
        M_RUN: begin
          chk("R2 no strobe stays in run", V_RUN);
        end
        M_SLI: begin
          chk("R2 sleep entry by wfi", V_SLEEP);
          evt_i = 1; xline_i = '1; rtc_i = '1; ext_rst_i = 1; wdog_rst_i = 1;
          irq_i = '1; irq_en_i = '0;
          tick; quiet;
          chk("R3 wfi sleep ignores masked irq and other sources", V_SLEEP);
          wfi_i = 1; wfe_i = 1; deep_i = 1; pdown_i = c[3];
          tick; quiet;
          chk("R11 strobe ignored in wfi sleep", V_SLEEP);
          irq_i = IRQ_W'(1) << (c % IRQ_W); irq_en_i = irq_i;
          tick; quiet;
          chk("R3 enabled irq wakes wfi sleep", V_RUN);
        end
        M_SLE: begin
          chk("R2 sleep entry by wfe", V_SLEEP);
          irq_i = '1; irq_en_i = '1; xline_i = '1; rtc_i = '1;
          tick; quiet;
          chk("R4 wfe sleep ignores enabled irq", V_SLEEP);
          wfe_i = 1; deep_i = 1; pdown_i = c[3];
          tick; quiet;
          chk("R11 strobe ignored in wfe sleep", V_SLEEP);
          evt_i = 1;
          tick; quiet;
          chk("R4 event wakes wfe sleep", V_RUN);
        end
        M_STOP: begin
          chk("R5 stop entry", stop_v(lp));
          irq_i = '1; irq_en_i = '1; evt_i = 1; rtc_i = '1;
          ext_rst_i = 1; wdog_rst_i = 1; wkpin_i = 1;
          lpreg_i = ~lp; wfi_i = 1; deep_i = 1; pdown_i = 1;
          tick; quiet; wkpin_i = 0;
          chk("R6 R11 stop holds against other sources", stop_v(lp));
          tick;
          chk("R5 regulator mode held in stop", stop_v(lp));
          xline_i = EXT_W'(1) << (c % EXT_W);
          tick; quiet;
          chk("R6 stop exit restores oscillator first", V_RCV);
          tick;
          chk("R6 R10 run after stop exit without reset", V_RUN);
        end
        default: begin
          chk("R7 standby entry", V_STBY);
          xline_i = '1; irq_i = '1; irq_en_i = '1; evt_i = 1;
          wfi_i = 1; deep_i = 1;
          tick; quiet;
          chk("R8 R11 standby ignores lines irq event", V_STBY);
          case (c % 8)
            0: wkpin_i = 1;
            6: ext_rst_i = 1;
            7: wdog_rst_i = 1;
            default: rtc_i = RTC_W'(1) << ((c % 8) - 1);
          endcase
          tick; quiet;
          chk("R8 standby wake gives reset request", V_SRST);
          wkpin_i = 0;
          tick;
          chk("R10 reset request lasts one cycle", V_RUN);
        end
      endcase
    end

    // R9: pin high before entry must not wake Standby
    wkpin_i = 1;
    tick;
    wfe_i = 1; deep_i = 1; pdown_i = 1;
    tick; quiet;
    chk("R9 standby entered with pin high", V_STBY);
    tick; tick;
    chk("R9 held pin level does not wake", V_STBY);
    wkpin_i = 0;
    tick;
    chk("R9 pin fall does not wake", V_STBY);
    wkpin_i = 1;
    tick;
    chk("R9 later pin rise wakes", V_SRST);
    tick;
    chk("R10 run after pin wake", V_RUN);
    wkpin_i = 0;
    tick;

    // R5: low-power regulator clear, then wake and check stby_rst stays low
    wfi_i = 1; deep_i = 1; lpreg_i = 0;
    tick; quiet;
    chk("R5 stop with full-power regulator", stop_v(1'b0));
    xline_i = '1;
    tick; quiet;
    chk("R6 all lines wake stop", V_RCV);
    tick;
    chk("R10 no reset after stop", V_RUN);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule